// File: doc/BRIEF.md
# I2C Master Clock-Line Phase Sequencer

This block produces the clock line of an I2C master. It runs on a fast system clock and advances only on a one-cycle tick enable that stands for the slower I2C timing clock. Every SCL period is built from whole ticks. One tick pulls the line low. The next tick checks that the line really is low. The third tick lets the line go. The remaining ticks read the line back until the high level has been confirmed. A mode select picks a five-tick period (normal) or a four-tick period (fast). A 500 kHz tick rate therefore gives 100 kHz or 125 kHz on SCL.

The line is open-drain. The block only ever asserts a drive-low request, and a pull-up does the rest. The raw line level comes back through a synchronizer. A slave that holds the line low after release is stretching the clock. The sequencer keeps the line released and re-reads it on every tick until it sees high, then confirms high on extra ticks before it starts the next period. Single-cycle strobes mark the start of each low phase and the end of each confirmed high phase, for use by the data and START/STOP logic. A line that reads high while the block is driving it low raises a bus-error pulse and stops the sequence.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, `scl_pull_low`, `low_start_stb`, `high_done_stb` and `bus_fault` are all 0.
- R2: With `fast_mode`=0 and no stretching, successive `low_start_stb` pulses are five ticks apart, and `high_done_stb` follows each `low_start_stb` by four ticks. State and outputs change only in the cycle after a sampled `tick_en`.
- R3: With `fast_mode`=1 and no stretching, successive `low_start_stb` pulses are four ticks apart, and `high_done_stb` follows `low_start_stb` by three ticks.
- R4: `scl_pull_low` rises with `low_start_stb` and stays 1 for exactly two ticks. It is then 0 for the rest of the period.
- R5: `low_start_stb` and `high_done_stb` are one system cycle wide, and they are never high together.
- R6: In normal mode, a high-phase sample that reads low keeps `scl_pull_low` at 0 and re-samples on every tick. After the first high sample, two more high samples are needed before `high_done_stb`.
- R7: In fast mode, after a stretch, one more high sample after the first is needed before `high_done_stb`.
- R8: If the line reads high on the second tick of a period, `bus_fault` pulses for one cycle with `scl_pull_low`=0. That period gives no `high_done_stb`, and the block returns to idle.
- R9: Clearing `run` during a period lets that period end with its `high_done_stb`. No further `low_start_stb` follows, and the line stays released.
- R10: `fast_mode` is taken only on the tick that starts a period. A change during a period does not alter that period's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle I2C timing tick |
| run | input | 1 | Start and continue SCL periods |
| fast_mode | input | 1 | 1 = four-tick period, 0 = five-tick period |
| scl_in | input | 1 | Raw SCL line level (asynchronous) |
| scl_pull_low | output | 1 | 1 = drive SCL low, 0 = release |
| low_start_stb | output | 1 | Pulse on the tick that begins the low phase |
| high_done_stb | output | 1 | Pulse after the final high verification sample |
| bus_fault | output | 1 | Pulse when the line is high during the low check |

## Verification
Two inputs are read on the same tick that starts a period: the mode select and the run request. Both are also the inputs whose late changes must not reach a period that is already running. The bench changes `fast_mode`, and separately drops `run`, in the cycle where `low_start_stb` is seen. That is the cycle just after the starting tick was taken. The result is judged from the distance, in system cycles, from that strobe to the next `high_done_stb`, which must still equal the old mode's length. For the new mode, the bench checks the length of the following period. For the dropped request, it checks that no further period starts.

// File: rtl/scl_phase_pkg.sv
package scl_phase_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PULL  = 2'd1,
    PH_LOWOK = 2'd2,
    PH_HIGH  = 2'd3
  } scl_phase_e;

endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_sync
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b1;
          else        stage_q[i] <= line_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b1;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign line_sync = stage_q[STAGES-1];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_phase_pkg::*;
#(
  parameter int SLOW_CONFIRM = 2,
  parameter int FAST_CONFIRM = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run,
  input  logic fast_mode,
  input  logic line_hi,
  output logic pull_low,
  output logic low_stb,
  output logic done_stb,
  output logic fault_stb
);
  localparam int MAX_NEED = SLOW_CONFIRM > FAST_CONFIRM ? SLOW_CONFIRM + 1 : FAST_CONFIRM + 1;
  localparam int CNT_W    = $clog2(MAX_NEED + 1);

  scl_phase_e       ph_q, ph_d;
  logic [CNT_W-1:0] hi_cnt_q, hi_cnt_d;
  logic             fast_q, fast_d;
  logic             stretched_q, stretched_d;
  logic             pull_q, pull_d;
  logic             low_stb_q, low_stb_d;
  logic             done_q, done_d;
  logic             fault_q, fault_d;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] hi_cnt_inc;

  always_comb begin
    need = fast_q ? CNT_W'(FAST_CONFIRM) : CNT_W'(SLOW_CONFIRM);
    if (stretched_q) need = need + CNT_W'(1);
    hi_cnt_inc = hi_cnt_q + CNT_W'(1);
  end

  always_comb begin
    ph_d        = ph_q;
    hi_cnt_d    = hi_cnt_q;
    fast_d      = fast_q;
    stretched_d = stretched_q;
    pull_d      = pull_q;
    low_stb_d   = 1'b0;
    done_d      = 1'b0;
    fault_d     = 1'b0;
    if (tick_en) begin
      unique case (ph_q)
        PH_IDLE: begin
          if (run) begin
            ph_d        = PH_PULL;
            pull_d      = 1'b1;
            fast_d      = fast_mode;
            stretched_d = 1'b0;
            hi_cnt_d    = '0;
            low_stb_d   = 1'b1;
          end
        end
        PH_PULL: begin
          if (line_hi) begin
            ph_d    = PH_IDLE;
            pull_d  = 1'b0;
            fault_d = 1'b1;
          end else begin
            ph_d = PH_LOWOK;
          end
        end
        PH_LOWOK: begin
          ph_d   = PH_HIGH;
          pull_d = 1'b0;
        end
        PH_HIGH: begin
          if (!line_hi) begin
            stretched_d = 1'b1;
            hi_cnt_d    = '0;
          end else if (hi_cnt_inc >= need) begin
            ph_d     = PH_IDLE;
            hi_cnt_d = '0;
            done_d   = 1'b1;
          end else begin
            hi_cnt_d = hi_cnt_inc;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      hi_cnt_q    <= '0;
      fast_q      <= 1'b0;
      stretched_q <= 1'b0;
      pull_q      <= 1'b0;
      low_stb_q   <= 1'b0;
      done_q      <= 1'b0;
      fault_q     <= 1'b0;
    end else begin
      ph_q        <= ph_d;
      hi_cnt_q    <= hi_cnt_d;
      fast_q      <= fast_d;
      stretched_q <= stretched_d;
      pull_q      <= pull_d;
      low_stb_q   <= low_stb_d;
      done_q      <= done_d;
      fault_q     <= fault_d;
    end
  end

  assign pull_low  = pull_q;
  assign low_stb   = low_stb_q;
  assign done_stb  = done_q;
  assign fault_stb = fault_q;

  // R2: nothing moves between ticks
  assert_still_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(pull_q) && !low_stb_q && !done_q && !fault_q));

  // R4: a low phase begins with the line being pulled
  assert_pull_with_low_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    low_stb_q |-> pull_q);

  // R5: the two phase strobes never overlap
  assert_strobes_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_stb_q && done_q));

  // R6: a low read during the high phase leaves the line released
  assert_stretch_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && ph_q == PH_HIGH && !line_hi) |=> (!pull_q && ph_q == PH_HIGH));

  // R8: a fault releases the line and ends the period without completion
  assert_fault_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> (!pull_q && !done_q && ph_q == PH_IDLE));

  // R10: the latched mode holds for the whole period
  assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && !(tick_en && ph_q == PH_IDLE)) |=> $stable(fast_q));
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int SYNC_STAGES  = 2,
  parameter int SLOW_CONFIRM = 2,
  parameter int FAST_CONFIRM = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run,
  input  logic fast_mode,
  input  logic scl_in,
  output logic scl_pull_low,
  output logic low_start_stb,
  output logic high_done_stb,
  output logic bus_fault
);
  logic rst_n_int;
  logic line_hi;

  scl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .line_raw  (scl_in),
    .line_sync (line_hi)
  );

  scl_phase_fsm #(
    .SLOW_CONFIRM (SLOW_CONFIRM),
    .FAST_CONFIRM (FAST_CONFIRM)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick_en   (tick_en),
    .run       (run),
    .fast_mode (fast_mode),
    .line_hi   (line_hi),
    .pull_low  (scl_pull_low),
    .low_stb   (low_start_stb),
    .done_stb  (high_done_stb),
    .fault_stb (bus_fault)
  );
endmodule

// File: tb/test_scl_phase_gen.sv
`timescale 1ns/1ps
module test_scl_phase_gen;
  logic clk, rst_n, tick_en, run, fast_mode, scl_in;
  logic scl_pull_low, low_start_stb, high_done_stb, bus_fault;
  logic slave_hold, stuck_high;
  logic [1:0] tdiv;
  int cyc, n_chk, n_bad;
  bit finished;

  scl_phase_gen i_scl_phase_gen (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run), .fast_mode(fast_mode),
    .scl_in(scl_in), .scl_pull_low(scl_pull_low), .low_start_stb(low_start_stb),
    .high_done_stb(high_done_stb), .bus_fault(bus_fault));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // tick every fourth system cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin tdiv <= '0; cyc <= 0; end
    else begin tdiv <= tdiv + 2'd1; cyc <= cyc + 1; end
  end
  assign tick_en = (tdiv == 2'd3);
  assign scl_in  = stuck_high ? 1'b1 : (!scl_pull_low && !slave_hold);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_low(output int t);
    t = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (low_start_stb) begin t = cyc; return; end
    end
  endtask

  task automatic wait_done(output int t);
    t = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (high_done_stb) begin t = cyc; return; end
    end
  endtask

  task automatic go_idle();
    run = 1'b0; slave_hold = 1'b0; stuck_high = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 pull", int'(scl_pull_low), 0);
    check("R1 strobes", int'(low_start_stb | high_done_stb), 0);
    check("R1 fault", int'(bus_fault), 0);
  endtask

  task automatic t_period(input bit fm, input string req);
    int a, d, b, n;
    fast_mode = fm; run = 1'b1;
    wait_low(a);
    check({req, " pull at start R4"}, int'(scl_pull_low), 1);
    check({req, " strobes apart R5"}, int'(high_done_stb), 0);
    n = 0;
    while (scl_pull_low && n < 100) begin n++; @(negedge clk); end
    check("R4 pull length", n, 8);
    wait_done(d);
    check({req, " low->done"}, d - a, fm ? 12 : 16);
    @(negedge clk);
    check("R5 done width", int'(high_done_stb), 0);
    wait_low(b);
    check({req, " period"}, b - a, fm ? 16 : 20);
    go_idle();
  endtask

  task automatic t_stretch(input bit fm, input string req);
    int a, d;
    fast_mode = fm; run = 1'b1;
    wait_low(a);
    run = 1'b0;
    slave_hold = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check({req, " released while held R6"}, int'(scl_pull_low), 0);
    check({req, " no early done"}, int'(high_done_stb), 0);
    slave_hold = 1'b0;
    wait_done(d);
    check({req, " stretched low->done"}, d - a, fm ? 28 : 32);
    go_idle();
  endtask

  task automatic t_fault();
    int a, f;
    stuck_high = 1'b1; fast_mode = 1'b0; run = 1'b1;
    wait_low(a);
    f = -1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (high_done_stb) check("R8 no done", 1, 0);
      if (bus_fault) begin f = cyc; run = 1'b0; break; end
    end
    check("R8 fault delay", f - a, 4);
    check("R8 released", int'(scl_pull_low), 0);
    @(negedge clk);
    check("R8 fault width", int'(bus_fault), 0);
    wait_done(f);
    check("R8 no done afterwards", f, -1);
    go_idle();
  endtask

  task automatic t_disable();
    int a, d, b;
    fast_mode = 1'b0; run = 1'b1;
    wait_low(a);
    run = 1'b0;
    wait_done(d);
    check("R9 period completes", d - a, 16);
    wait_low(b);
    check("R9 no restart", b, -1);
    check("R9 line released", int'(scl_pull_low), 0);
    go_idle();
  endtask

  task automatic t_mode_change();
    int a, d, b, e;
    fast_mode = 1'b0; run = 1'b1;
    wait_low(a);
    fast_mode = 1'b1;
    wait_done(d);
    check("R10 current period keeps slow", d - a, 16);
    wait_low(b);
    check("R10 slow period length", b - a, 20);
    wait_done(e);
    check("R10 next period fast", e - b, 12);
    go_idle();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    run = 1'b0; fast_mode = 1'b0; slave_hold = 1'b0; stuck_high = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    t_period(1'b0, "R2");
    t_period(1'b1, "R3");
    t_stretch(1'b0, "R6");
    t_stretch(1'b1, "R7");
    t_fault();
    t_disable();
    t_mode_change();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule